// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is a serial test access port for board-level interconnect test. A four-wire serial interface (test clock, mode select, data in, data out) plus an active-low asynchronous port reset drives a sixteen-state controller. The controller steps through capture, shift and update phases of either a 4-bit instruction register or one of three data registers: a 1-bit bypass register, a fixed 32-bit identification register, or a boundary register of three cells per pin.

The instruction held in the update stage of the instruction register decides which data register sits between serial in and serial out. It also decides whether the pad-side outputs follow the core, follow the boundary register's update stage, or are all forced to float. Two of the instructions keep the short bypass path selected while they override the pads. A board tester can therefore hold the pads in a known or floating state and still pass other devices' data through this one with a single bit of delay.

Top module: `scan_tap`

## Requirements
- R1: While rst_ni is low the controller is held in Test-Logic-Reset and the active instruction is IDCODE. tdo_oe_o is 0, float_o is 0, and pin_out_o and pin_oe_o equal core_out_i and core_oe_i.
- R2: Five rising tck edges with tms_i high bring the controller to Test-Logic-Reset from any state, and it stays there while tms_i stays high.
- R3: Five consecutive rising tck edges with both tms_i and tdi_i high force Test-Logic-Reset.
- R4: Every cycle spent in Test-Logic-Reset loads the active instruction with IDCODE (4'b0001), so a data scan that follows reads the identification register.
- R5: The opcodes are EXTEST=4'b0000, IDCODE=4'b0001, SAMPLE=4'b0010, TRIBYP=4'b0011, SETBYP=4'b0100 and BYPASS=4'b1111. EXTEST and SAMPLE select the boundary register, IDCODE selects the identification register, and every other code selects the bypass register.
- R6: The identification register captures 32'h103CBEFD. Bits 31:28 hold the version 4'h1, bits 27:12 the part number 16'h03CB, bits 11:8 the bank code 4'hE, bits 7:1 the maker code 7'h7E, and bit 0 is 1.
- R7: Capture-IR loads 4'b0001 into the instruction shift stage. The first four bits shifted out are therefore 1,0,0,0.
- R8: The bypass register captures 0 and delays tdi_i by exactly one shift cycle.
- R9: The boundary register is 3*NUM_PINS cells wide. Bits [N-1:0] capture pin_in_i, bits [2N-1:N] capture core_out_i and bits [3N-1:2N] capture core_oe_i. Its update stage changes only on Update-DR while EXTEST or SAMPLE is active, and it holds its value during shifting.
- R10: While EXTEST or SETBYP is active, pin_out_o is driven from update bits [2N-1:N] and pin_oe_o from update bits [3N-1:2N]. Under any other instruction the pads follow the core.
- R11: While TRIBYP is active, pin_oe_o is all zero and float_o is 1.
- R12: tdo_o and tdo_oe_o change on the falling edge of tck. tdo_oe_o is 1 only in Shift-IR and Shift-DR, and bits leave least significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous port reset |
| tms_i | input | 1 | Mode select, sampled on rising tck |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, falling-edge registered |
| tdo_oe_o | output | 1 | Enable for tdo_o (high only while shifting) |
| pin_in_i | input | NUM_PINS | Pad input levels |
| core_out_i | input | NUM_PINS | Core output values |
| core_oe_i | input | NUM_PINS | Core output enables |
| pin_out_o | output | NUM_PINS | Output value to pads |
| pin_oe_o | output | NUM_PINS | Output enable to pads |
| float_o | output | 1 | Global output-float indication |

## Verification
The bench reads the identification word after port reset, after a five-cycle TMS escape and after a TMS-plus-TDI escape. A design that failed to reload the instruction on Test-Logic-Reset would return a stale bypass bit stream instead of 32'h103CBEFD. It sends an undefined opcode, and a decoder that fell through to another register would shift out something other than the one-cycle-delayed data. It checks that the pads hold the old boundary values throughout an EXTEST shift and that they keep those values through a later bypass scan under SETBYP. A boundary register without a separate update stage would make the pads ripple or change on the wrong scan. It also checks that TRIBYP clears every enable, and that the scan-out is enabled only in the shift states, on the falling edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int unsigned IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_TRIBYP  = 4'b0011;
  localparam logic [IR_W-1:0] OP_SETBYP  = 4'b0100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {SEL_BYPASS, SEL_ID, SEL_BSR} dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    drive_pins;
    logic    float_pins;
  } ir_dec_t;

  function automatic ir_dec_t decode_op(logic [IR_W-1:0] op);
    ir_dec_t d;
    d = '{sel: SEL_BYPASS, drive_pins: 1'b0, float_pins: 1'b0};
    case (op)
      OP_EXTEST: begin d.sel = SEL_BSR; d.drive_pins = 1'b1; end
      OP_SAMPLE: d.sel = SEL_BSR;
      OP_IDCODE: d.sel = SEL_ID;
      OP_TRIBYP: d.float_pins = 1'b1;
      OP_SETBYP: d.drive_pins = 1'b1;
      default:   d.sel = SEL_BYPASS;  // undefined codes act as bypass
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
#(
  parameter int unsigned RESET_RUN = 5
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  input  logic       tdi_i,
  output tap_state_e state_o
);
  localparam int unsigned CW = $clog2(RESET_RUN + 1);

  tap_state_e state_q, state_d;
  logic [CW-1:0] run_q;
  logic          run_hit;

  assign run_hit = tms_i && tdi_i && (run_q == CW'(RESET_RUN - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_TLR;
      run_q   <= '0;
    end else begin
      state_q <= run_hit ? ST_TLR : state_d;
      if (tms_i && tdi_i) run_q <= run_hit ? '0 : run_q + 1'b1;
      else                run_q <= '0;
    end
  end

  assign state_o = state_q;

  assert_tms_hold_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR && tms_i) |=> (state_q == ST_TLR));

  assert_tms_tdi_escape_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    run_hit |=> (state_q == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  output logic [IR_W-1:0] ir_o,
  output logic            so_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      ir_q <= OP_IDCODE;
    end else begin
      case (state_i)
        ST_CAP_IR: sr_q <= IR_CAPTURE;
        ST_SHF_IR: sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        default:   sr_q <= sr_q;
      endcase
      if (state_i == ST_TLR)         ir_q <= OP_IDCODE;
      else if (state_i == ST_UPD_IR) ir_q <= sr_q;
    end
  end

  assign ir_o = ir_q;
  assign so_o = sr_q[0];

  assert_tlr_idcode_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_TLR) |=> (ir_q == OP_IDCODE));

  assert_ir_hold_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_TLR && state_i != ST_UPD_IR) |=> $stable(ir_q));

endmodule

// File: rtl/tap_dr.sv
module tap_dr #(
  parameter int unsigned W = 1
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         tdi_i,
  input  logic         cap_i,
  input  logic         shift_i,
  input  logic [W-1:0] cap_val_i,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q, shifted;

  if (W == 1) begin : g_single
    assign shifted = tdi_i;
  end else begin : g_multi
    assign shifted = {tdi_i, sr_q[W-1:1]};
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (cap_i)   sr_q <= cap_val_i;
    else if (shift_i) sr_q <= shifted;
  end

  assign sr_o = sr_q;

  assert_dr_idle_R12: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!cap_i && !shift_i) |=> $stable(sr_q));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import tap_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 4,
  parameter int unsigned RESET_RUN  = 5,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h03CB,
  parameter logic [3:0]  ID_BANK    = 4'hE,
  parameter logic [6:0]  ID_MAKER   = 7'h7E
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tms_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  output logic                tdo_oe_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  input  logic [NUM_PINS-1:0] core_out_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                float_o
);
  localparam int unsigned N     = NUM_PINS;
  localparam int unsigned BSR_W = 3 * N;
  localparam logic [31:0] ID_VALUE = {ID_VERSION, ID_PART, ID_BANK, ID_MAKER, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so;
  ir_dec_t         dec;
  logic            cap_dr, shf_dr;
  logic            byp_sr;
  logic [31:0]     id_sr;
  logic [BSR_W-1:0] bsr_sr, bsr_upd_q;
  logic            dr_so;
  logic            tdo_q, tdo_oe_q;

  tap_fsm #(.RESET_RUN(RESET_RUN)) u_fsm (
    .tck_i, .rst_ni, .tms_i, .tdi_i, .state_o(state)
  );

  tap_ir u_ir (
    .tck_i, .rst_ni, .tdi_i, .state_i(state), .ir_o(ir), .so_o(ir_so)
  );

  assign dec    = decode_op(ir);
  assign cap_dr = (state == ST_CAP_DR);
  assign shf_dr = (state == ST_SHF_DR);

  tap_dr #(.W(1)) u_bypass (
    .tck_i, .rst_ni, .tdi_i,
    .cap_i(cap_dr && dec.sel == SEL_BYPASS), .shift_i(shf_dr && dec.sel == SEL_BYPASS),
    .cap_val_i(1'b0), .sr_o(byp_sr)
  );

  tap_dr #(.W(32)) u_id (
    .tck_i, .rst_ni, .tdi_i,
    .cap_i(cap_dr && dec.sel == SEL_ID), .shift_i(shf_dr && dec.sel == SEL_ID),
    .cap_val_i(ID_VALUE), .sr_o(id_sr)
  );

  tap_dr #(.W(BSR_W)) u_bsr (
    .tck_i, .rst_ni, .tdi_i,
    .cap_i(cap_dr && dec.sel == SEL_BSR), .shift_i(shf_dr && dec.sel == SEL_BSR),
    .cap_val_i({core_oe_i, core_out_i, pin_in_i}), .sr_o(bsr_sr)
  );

  // Parallel stage of the boundary cells: holds through shifting
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                                     bsr_upd_q <= '0;
    else if (state == ST_UPD_DR && dec.sel == SEL_BSR) bsr_upd_q <= bsr_sr;
  end

  always_comb begin
    unique case (dec.sel)
      SEL_ID:  dr_so = id_sr[0];
      SEL_BSR: dr_so = bsr_sr[0];
      default: dr_so = byp_sr;
    endcase
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_oe_q <= 1'b0;
    end else begin
      tdo_q    <= (state == ST_SHF_IR) ? ir_so : dr_so;
      tdo_oe_q <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = tdo_oe_q;

  assign pin_out_o = dec.drive_pins ? bsr_upd_q[2*N-1:N] : core_out_i;
  assign pin_oe_o  = dec.float_pins ? '0
                   : dec.drive_pins ? bsr_upd_q[3*N-1:2*N] : core_oe_i;
  assign float_o   = dec.float_pins;

  assert_tdo_oe_shift_R12: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  assert_upd_hold_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state == ST_UPD_DR && dec.sel == SEL_BSR) |=> $stable(bsr_upd_q));

  assert_float_R11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir == OP_TRIBYP) |-> (pin_oe_o == '0 && float_o));

  assert_drive_R10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir == OP_EXTEST || ir == OP_SETBYP) |-> (pin_out_o == bsr_upd_q[2*N-1:N]));

endmodule

// File: tb/scan_tap_bench.sv
module scan_tap_bench;
  localparam int N = 4;
  localparam logic [31:0] ID_EXP = 32'h103CBEFD;

  logic tck = 1'b0;
  logic rst_ni, tms_i, tdi_i;
  logic tdo_o, tdo_oe_o, float_o;
  logic [N-1:0] pin_in_i, core_out_i, core_oe_i, pin_out_o, pin_oe_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string req_q[$];
  bit hold_on = 1'b0;
  logic [N-1:0] hold_out, hold_oe;

  always #10 tck = ~tck;  // 50 MHz

  scan_tap #(.NUM_PINS(N)) u_scan_tap (
    .tck_i(tck), .rst_ni, .tms_i, .tdi_i, .tdo_o, .tdo_oe_o,
    .pin_in_i, .core_out_i, .core_oe_i, .pin_out_o, .pin_oe_o, .float_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: every enabled scan-out bit is compared with the scoreboard
  always @(negedge tck) begin
    #2;
    if (tdo_oe_o === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected scan-out actual=%b expected=none", tdo_o);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        if (tdo_o !== e) begin
          failures++;
          $display("FAIL %s scan-out bit actual=%b expected=%b", r, tdo_o, e);
        end
      end
    end
  end

  task automatic step(logic m, logic d);
    @(negedge tck);
    tms_i = m;
    tdi_i = d;
  endtask

  task automatic settle();
    @(posedge tck);
    #3;
  endtask

  // From Run-Test/Idle, load an opcode and return to Run-Test/Idle
  task automatic load_ir(logic [3:0] op);
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back((i == 0) ? 1'b1 : 1'b0);
      req_q.push_back("R7");
    end
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, op[i]);
    step(1, 0); step(0, 0);
    settle();
  endtask

  task automatic scan_dr(int n, logic [31:0] din, logic [31:0] exp, string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp[i]);
      req_q.push_back(req);
    end
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      #1;
      if (hold_on) begin
        chk("R9", {28'd0, pin_out_o}, {28'd0, hold_out}, "pin_out during shift");
        chk("R9", {28'd0, pin_oe_o}, {28'd0, hold_oe}, "pin_oe during shift");
      end
    end
    step(1, 0); step(0, 0);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    rst_ni = 1'b0; tms_i = 1'b1; tdi_i = 1'b0;
    pin_in_i = 4'h9; core_out_i = 4'h6; core_oe_i = 4'hC;
    repeat (3) @(posedge tck);
    #3;
    // R1: reset state
    chk("R1", {31'd0, tdo_oe_o}, 0, "tdo_oe in reset");
    chk("R1", {31'd0, float_o}, 0, "float in reset");
    chk("R1", {28'd0, pin_out_o}, 32'h6, "pin_out follows core");
    chk("R1", {28'd0, pin_oe_o}, 32'hC, "pin_oe follows core");
    @(negedge tck); rst_ni = 1'b1;

    // R4/R6: identification read after reset
    step(0, 0);
    settle();
    chk("R12", {31'd0, tdo_oe_o}, 0, "tdo_oe idle");
    scan_dr(32, 32'h0, ID_EXP, "R6");

    // R8: bypass one-cycle delay
    load_ir(4'b1111);
    scan_dr(8, 32'hA5, 32'hA5 << 1, "R8");
    // R5: undefined code acts as bypass
    load_ir(4'b0101);
    scan_dr(8, 32'h3C, 32'h3C << 1, "R5");

    // R2: five TMS-high edges, then ID again (R4)
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    settle();
    scan_dr(32, 32'h0, ID_EXP, "R4");

    // R3: TMS and TDI high five edges
    load_ir(4'b1111);
    for (int i = 0; i < 5; i++) step(1, 1);
    step(0, 0);
    settle();
    scan_dr(32, 32'h0, ID_EXP, "R3");

    // R9: SAMPLE capture layout, preload update stage; pads stay on core (R10)
    load_ir(4'b0010);
    scan_dr(12, 32'hA50, 32'hC69, "R9");
    chk("R10", {28'd0, pin_out_o}, 32'h6, "SAMPLE leaves pin_out on core");
    chk("R10", {28'd0, pin_oe_o}, 32'hC, "SAMPLE leaves pin_oe on core");

    // R10: EXTEST drives preloaded values; held during shift (R9)
    load_ir(4'b0000);
    chk("R10", {28'd0, pin_out_o}, 32'h5, "EXTEST pin_out");
    chk("R10", {28'd0, pin_oe_o}, 32'hA, "EXTEST pin_oe");
    hold_out = 4'h5; hold_oe = 4'hA; hold_on = 1'b1;
    scan_dr(12, 32'h3F0, 32'hC69, "R9");
    hold_on = 1'b0;
    chk("R10", {28'd0, pin_out_o}, 32'hF, "EXTEST pin_out after update");
    chk("R10", {28'd0, pin_oe_o}, 32'h3, "EXTEST pin_oe after update");

    // R10: SETBYP drives from update stage with bypass selected (R5)
    load_ir(4'b0100);
    scan_dr(4, 32'hB, 32'h6, "R5");
    chk("R10", {28'd0, pin_out_o}, 32'hF, "SETBYP pin_out");
    chk("R9", {28'd0, pin_oe_o}, 32'h3, "update stage unchanged by bypass scan");

    // R11: TRIBYP floats everything
    load_ir(4'b0011);
    chk("R11", {28'd0, pin_oe_o}, 32'h0, "TRIBYP pin_oe");
    chk("R11", {31'd0, float_o}, 32'h1, "TRIBYP float");
    scan_dr(4, 32'h9, 32'h2, "R8");

    // R1: asynchronous reset mid-run
    @(negedge tck); #5; rst_ni = 1'b0; #2;
    chk("R1", {31'd0, float_o}, 0, "float cleared by reset");
    chk("R1", {28'd0, pin_oe_o}, 32'hC, "pin_oe back to core");
    @(negedge tck); rst_ni = 1'b1; tms_i = 1'b0;
    settle();
    scan_dr(32, 32'h0, ID_EXP, "R1");

    repeat (3) @(posedge tck);
    chk("R12", exp_q.size(), 0, "scoreboard drained");
    done = 1'b1;
    report();
  end
endmodule